// File: doc/BRIEF.md
# Center-Aligned PWM Timer

This block is a timer with several compare channels that produce center-aligned pulse-width modulated outputs. A prescaler divides the clock into count steps. In dual-slope operation the counter climbs from zero to a programmable period value, turns, and descends back to zero. Each channel output rises when the counter passes its compare value on the way up and falls when the counter passes it on the way down, so every pulse is centred on the turnaround at the period value. A single-slope sawtooth mode is also provided for comparison.

The period and the compare values are double-buffered. Software-side writes land in shadow registers and reach the active registers only at update points: on reaching zero, and also on reaching the period value when the combined event mode is selected. When buffering is switched off, writes take effect on the next cycle. One-cycle strobes mark the counter arriving at the period value and at zero, and a mode input selects which of them fire. Configuration arrives on plain input ports. Dropping the enable input parks the counter at zero, counting up, with every output low.

Top module: `cslope_pwm`

## Requirements
- R1: In dual-slope mode (`slope_dual`=1) the count steps 0,1,…,PER,PER−1,…,1,0,… so one period is 2·PER steps. `dir_down` is 1 while the count is at PER and while it descends, and 0 at zero and while it ascends.
- R2: In dual-slope mode, a channel with compare value C (0 < C < PER) is high from the step at which the count reaches C ascending until the step at which it reaches C descending. This gives 2·(PER−C) high steps per period.
- R3: In dual-slope mode a compare value of 0 keeps the channel high for the whole run, and a compare value ≥ PER keeps it low, including at both turnarounds.
- R4: `presc_sel` codes 0..7 divide the count rate by 1, 2, 4, 8, 16, 64, 256 and 1024. The count advances once every N clocks, and the first advance comes N clocks after counting starts.
- R5: With `buf_en`=1, writes to the period or compare values go to shadow registers. The active values change only when the count reaches zero, never in the middle of a slope.
- R6: With `buf_en`=1, dual-slope mode and `evt_mode` of 2 or 3, the shadow values are also loaded when the count reaches PER.
- R7: `evt_top` and `evt_zero` pulse for one cycle, in the first cycle the count holds PER or 0 after a step. In dual-slope mode `evt_mode` 0 enables only the PER strobe, 1 only the zero strobe, and 2 or 3 both. They never pulse together.
- R8: In single-slope mode (`slope_dual`=0) the count steps 0..PER and wraps, giving a period of PER+1 steps. A channel is high while count < C, `dir_down` stays 0, and both strobes fire.
- R9: One cycle after `enable` is sampled low, the count is 0, `dir_down` is 0, and all outputs and strobes are low. While disabled, the active values follow the shadow values.
- R10: With `buf_en`=0 a write reaches the active register at the clock edge that samples it.
- R11: After reset the count is 0, `dir_down` is 0, and all outputs and strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the timer; low parks it at zero |
| slope_dual | input | 1 | 1 = up/down counting, 0 = sawtooth |
| presc_sel | input | 3 | Prescaler code (R4) |
| evt_mode | input | 2 | Strobe and update-point selection (R6, R7) |
| buf_en | input | 1 | 1 = shadowed writes, 0 = immediate writes |
| per_wr | input | 1 | Write strobe for the period value |
| per_in | input | CNT_W | Period value to write |
| cc_wr | input | NCH | Per-channel compare write strobes |
| cc_in | input | NCH·CNT_W | Compare values, channel i at bits [i·CNT_W +: CNT_W] |
| count_o | output | CNT_W | Current count |
| dir_down | output | 1 | 1 while at PER or descending |
| evt_top | output | 1 | One-cycle strobe on reaching PER |
| evt_zero | output | 1 | One-cycle strobe on reaching zero |
| wo | output | NCH | Channel waveform outputs |

## Verification
The bench sweeps every period from 1 to 5 with every compare value from 0 to PER+1, spread over two channels, in both slope modes, every event-mode code and the first three prescaler codes. The remaining prescaler codes are run at PER=1. Compare values of 0 and at or above PER separate the always-high and always-low corners from ordinary pulses. Each slower prescaler shows that steps occur once per N clocks and that strobes last only the first of those cycles. Directed runs write new values in the middle of a slope: one separates shadowed from immediate writes, and another separates a zero-only update from an update at both turnarounds by a compare change landing before the descending match.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the center-aligned PWM timer.
// Assumes prescaler divisors are powers of two up to 1024.
package pwm_pkg;
    localparam int PSC_W = 10;

    typedef enum logic [1:0] {
        EVM_TOP      = 2'd0,
        EVM_ZERO     = 2'd1,
        EVM_BOTH     = 2'd2,
        EVM_BOTH_ALT = 2'd3
    } evmode_e;

    // Terminal value of the prescaler for a select code (divisor minus one).
    function automatic logic [PSC_W-1:0] presc_limit(input logic [2:0] sel);
        int unsigned sh;
        sh = (sel <= 3'd4) ? int'(sel) : (2 * int'(sel) - 4);
        return PSC_W'((32'd1 << sh) - 32'd1);
    endfunction
endpackage

// File: rtl/pwm_prescale.sv
`timescale 1ns/1ps
// Prescaler: produces a one-cycle step pulse every N clocks while go is high.
// Assumes go drops whenever the timer is disabled, which restarts the count.
module pwm_prescale
    import pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [PSC_W-1:0] pcnt;
    logic [PSC_W-1:0] lim;

    assign lim  = presc_limit(sel);
    assign tick = go && (pcnt >= lim);

    // Divider counter, cleared when idle or after each step.
    always_ff @(posedge clk) begin
        if (!rst_n || !go)
            pcnt <= '0;
        else if (tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
// Up/down or sawtooth counter with direction state.
// dir_q is 1 at the period value and while descending; it is 0 at zero.
// Assumes per >= 1 for legal operation.
module pwm_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         tick,
    input  logic         dual,
    input  logic [W-1:0] per,
    output logic [W-1:0] cnt,
    output logic         dir_q,
    output logic         step_top,
    output logic         step_zero
);
    logic [W-1:0] nxt;
    logic         nxt_dir;

    // Next count and direction for the selected counting mode.
    always_comb begin
        if (dual) begin
            if (dir_q) begin
                nxt     = cnt - 1'b1;
                nxt_dir = (cnt != W'(1));
            end else begin
                nxt     = cnt + 1'b1;
                nxt_dir = (nxt >= per);
            end
        end else begin
            nxt     = (cnt >= per) ? '0 : cnt + 1'b1;
            nxt_dir = 1'b0;
        end
    end

    assign step_top  = tick && (dual ? (!dir_q && nxt_dir) : (nxt == per && nxt != '0));
    assign step_zero = tick && (nxt == '0);

    // Count state; parked at zero counting up while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt   <= '0;
            dir_q <= 1'b0;
        end else if (tick) begin
            cnt   <= nxt;
            dir_q <= nxt_dir;
        end else if (!dual) begin
            dir_q <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
// One compare channel: decodes the output level from count, direction and
// the active compare value. Assumes dir is 1 at the period value.
module pwm_channel #(
    parameter int W = 8
) (
    input  logic         run,
    input  logic         dual,
    input  logic [W-1:0] cnt,
    input  logic         dir,
    input  logic [W-1:0] cc,
    output logic         wo
);
    // Level: centered window in dual mode, leading pulse in sawtooth mode.
    always_comb begin
        if (!run)
            wo = 1'b0;
        else if (dual)
            wo = (cnt > cc) || (cnt == cc && !dir);
        else
            wo = (cnt < cc);
    end
endmodule

// File: rtl/cslope_pwm.sv
`timescale 1ns/1ps
// Center-aligned PWM timer top: prescaler, up/down counter, shadowed
// period and compare registers, event strobes and NCH output channels.
// Assumes configuration is held stable except for write strobes.
module cslope_pwm
    import pwm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int NCH   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               slope_dual,
    input  logic [2:0]         presc_sel,
    input  logic [1:0]         evt_mode,
    input  logic               buf_en,
    input  logic               per_wr,
    input  logic [CNT_W-1:0]   per_in,
    input  logic [NCH-1:0]     cc_wr,
    input  logic [NCH*CNT_W-1:0] cc_in,
    output logic [CNT_W-1:0]   count_o,
    output logic               dir_down,
    output logic               evt_top,
    output logic               evt_zero,
    output logic [NCH-1:0]     wo
);
    localparam logic [CNT_W-1:0] PER_RST = '1;

    evmode_e          mode;
    logic             run_q;
    logic             go;
    logic             tick;
    logic             step_top;
    logic             step_zero;
    logic             upd;
    logic             top_en;
    logic             zero_en;
    logic [CNT_W-1:0] per_sh;
    logic [CNT_W-1:0] per_act;

    assign mode    = evmode_e'(evt_mode);
    assign go      = run_q && enable;
    assign top_en  = !slope_dual || (mode != EVM_ZERO);
    assign zero_en = !slope_dual || (mode != EVM_TOP);
    assign upd     = step_zero ||
                     (step_top && slope_dual && (mode == EVM_BOTH || mode == EVM_BOTH_ALT));

    // Run flag: the first cycle after enable rises holds the count at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= enable;
    end

    pwm_prescale u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .sel   (presc_sel),
        .tick  (tick)
    );

    pwm_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (tick),
        .dual      (slope_dual),
        .per       (per_act),
        .cnt       (count_o),
        .dir_q     (dir_down),
        .step_top  (step_top),
        .step_zero (step_zero)
    );

    // Event strobes, registered to align with the new count value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_top  <= 1'b0;
            evt_zero <= 1'b0;
        end else begin
            evt_top  <= enable && step_top && top_en;
            evt_zero <= enable && step_zero && zero_en;
        end
    end

    // Period shadow register.
    always_ff @(posedge clk) begin
        if (!rst_n)      per_sh <= PER_RST;
        else if (per_wr) per_sh <= per_in;
    end

    // Active period: direct write, update point, or tracking while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                   per_act <= PER_RST;
        else if (per_wr && !buf_en)   per_act <= per_in;
        else if (upd || !run_q)       per_act <= per_sh;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [CNT_W-1:0] sh_q;
        logic [CNT_W-1:0] act_q;

        // Compare shadow register for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)        sh_q <= '0;
            else if (cc_wr[i]) sh_q <= cc_in[i*CNT_W +: CNT_W];
        end

        // Active compare value, loaded by the same rules as the period.
        always_ff @(posedge clk) begin
            if (!rst_n)                   act_q <= '0;
            else if (cc_wr[i] && !buf_en) act_q <= cc_in[i*CNT_W +: CNT_W];
            else if (upd || !run_q)       act_q <= sh_q;
        end

        pwm_channel #(.W(CNT_W)) u_ch (
            .run  (run_q),
            .dual (slope_dual),
            .cnt  (count_o),
            .dir  (dir_down),
            .cc   (act_q),
            .wo   (wo[i])
        );
    end
endmodule

// File: rtl/pwm_chk.sv
`timescale 1ns/1ps
// Assertion checker for cslope_pwm, attached by bind.
module pwm_chk #(
    parameter int W = 8,
    parameter int N = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         enable,
    input logic         dual,
    input logic         buf_en,
    input logic         run,
    input logic [W-1:0] per_act,
    input logic [W-1:0] count,
    input logic         dir_down,
    input logic         evt_top,
    input logic         evt_zero,
    input logic [N-1:0] wo
);
    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && dual && $past(dual)) |->
        (count == $past(count) || count == $past(count) + 1'b1 || count == $past(count) - 1'b1)); // R1

    AST_TOP_TURNS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (dual && evt_top) |-> dir_down); // R1

    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_top && evt_zero)); // R7

    AST_ZERO_EVT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        evt_zero |-> (count == '0)); // R7

    AST_IDLE_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (count == '0 && !dir_down && wo == '0 && !evt_top && !evt_zero)); // R9

    AST_PERIOD_HELD_MIDSLOPE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(buf_en) && count != '0 && !evt_top) |-> $stable(per_act)); // R5

    AST_SAWTOOTH_DIR_UP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run && !dual) |-> !dir_down); // R8
endmodule

bind cslope_pwm pwm_chk #(.W(CNT_W), .N(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .dual     (slope_dual),
    .buf_en   (buf_en),
    .run      (run_q),
    .per_act  (per_act),
    .count    (count_o),
    .dir_down (dir_down),
    .evt_top  (evt_top),
    .evt_zero (evt_zero),
    .wo       (wo)
);

// File: tb/cslope_pwm_tb.sv
`timescale 1ns/1ps
// Self-checking sweep bench for cslope_pwm.
module cslope_pwm_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        slope_dual;
    logic [2:0]  presc_sel;
    logic [1:0]  evt_mode;
    logic        buf_en;
    logic        per_wr;
    logic [7:0]  per_in;
    logic [1:0]  cc_wr;
    logic [15:0] cc_in;
    logic [7:0]  count_o;
    logic        dir_down;
    logic        evt_top;
    logic        evt_zero;
    logic [1:0]  wo;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cslope_pwm #(.CNT_W(8), .NCH(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .slope_dual(slope_dual),
        .presc_sel(presc_sel), .evt_mode(evt_mode), .buf_en(buf_en),
        .per_wr(per_wr), .per_in(per_in), .cc_wr(cc_wr), .cc_in(cc_in),
        .count_o(count_o), .dir_down(dir_down), .evt_top(evt_top),
        .evt_zero(evt_zero), .wo(wo)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    function automatic int ndiv(input int sel);
        case (sel)
            0: return 1;    1: return 2;   2: return 4;   3: return 8;
            4: return 16;   5: return 64;  6: return 256; default: return 1024;
        endcase
    endfunction

    // Load configuration while disabled; active values follow after two edges.
    task automatic load_cfg(input bit dual, input int sel, input int mode,
                            input int per, input int c0, input int c1);
        @(negedge clk);
        slope_dual = dual; presc_sel = sel[2:0]; evt_mode = mode[1:0]; buf_en = 1'b1;
        per_wr = 1'b1; per_in = per[7:0]; cc_wr = 2'b11; cc_in = {c1[7:0], c0[7:0]};
        @(negedge clk);
        per_wr = 1'b0; cc_wr = 2'b00;
        @(negedge clk);
    endtask

    task automatic idle_check();
        enable = 1'b0;
        @(negedge clk);
        chk("R9 count", count_o, 0);
        chk("R9 dir", dir_down, 0);
        chk("R9 wo", wo, 0);
        chk("R9 evt_top", evt_top, 0);
        chk("R9 evt_zero", evt_zero, 0);
    endtask

    // Run one configuration for two periods and compare every cycle.
    task automatic sweep_run(input bit dual, input int sel, input int mode,
                             input int per, input int c0, input int c1);
        int n, len, ncyc, k, p, ec, ed, ew, et, ez, cc;
        bit stepped;
        load_cfg(dual, sel, mode, per, c0, c1);
        n    = ndiv(sel);
        len  = dual ? 2 * per : per + 1;
        ncyc = 2 * len * n + 3;
        enable = 1'b1;
        for (int j = 0; j < ncyc; j++) begin
            @(negedge clk);
            k = j / n;
            p = k % len;
            stepped = (j > 0) && (j % n == 0);
            if (dual) begin
                ec = (p <= per) ? p : len - p;
                ed = (p >= per) ? 1 : 0;
            end else begin
                ec = p;
                ed = 0;
            end
            chk(dual ? ((n > 1) ? "R4 count" : "R1 count") : "R8 count", count_o, ec);
            chk(dual ? "R1 dir" : "R8 dir", dir_down, ed);
            for (int i = 0; i < 2; i++) begin
                cc = (i == 0) ? c0 : c1;
                if (dual) ew = (p >= cc && p < len - cc) ? 1 : 0;
                else      ew = (p < cc) ? 1 : 0;
                chk(dual ? ((cc == 0 || cc >= per) ? "R3 wo" : "R2 wo") : "R8 wo", wo[i], ew);
            end
            et = (stepped && p == per && (!dual || mode != 1)) ? 1 : 0;
            ez = (stepped && p == 0 && (!dual || mode != 0)) ? 1 : 0;
            chk("R7 evt_top", evt_top, et);
            chk("R7 evt_zero", evt_zero, ez);
        end
        idle_check();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL R1 watchdog expired: actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; slope_dual = 1'b1; presc_sel = 3'd0;
        evt_mode = 2'd0; buf_en = 1'b1; per_wr = 1'b0; per_in = 8'd0;
        cc_wr = 2'b00; cc_in = 16'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 count", count_o, 0);
        chk("R11 dir", dir_down, 0);
        chk("R11 wo", wo, 0);
        chk("R11 evt_top", evt_top, 0);
        chk("R11 evt_zero", evt_zero, 0);

        // Sweeps in both slope modes over periods, compare values, modes, prescalers.
        for (int d = 1; d >= 0; d--)
            for (int s = 0; s < 3; s++)
                for (int per = 1; per <= 5; per++)
                    for (int c = 0; c <= per + 1; c++)
                        sweep_run(d[0], s, (c + per) % 4, per, c, per + 1 - c);
        // R4 remaining prescaler codes
        for (int s = 3; s < 8; s++)
            sweep_run(1'b1, s, 2, 1, 0, 1);

        // R5: mid-slope period write is deferred to zero.
        load_cfg(1'b1, 0, 1, 4, 0, 0);
        enable = 1'b1;
        for (int j = 0; j <= 12; j++) begin
            @(negedge clk);
            if (j == 3)  chk("R5 count", count_o, 3);
            if (j == 4)  chk("R5 count", count_o, 4);
            if (j == 8)  chk("R5 count", count_o, 0);
            if (j == 10) chk("R5 count", count_o, 2);
            if (j == 11) chk("R5 count", count_o, 1);
            if (j == 12) chk("R5 count", count_o, 0);
            if (j == 0) begin per_wr = 1'b1; per_in = 8'd2; end
            if (j == 1) per_wr = 1'b0;
        end
        idle_check();

        // R6: compare write taken at the top in combined mode.
        load_cfg(1'b1, 0, 2, 4, 0, 0);
        enable = 1'b1;
        for (int j = 0; j <= 9; j++) begin
            @(negedge clk);
            if (j == 3) chk("R6 wo", wo[0], 1);
            if (j == 4) chk("R6 wo", wo[0], 1);
            if (j == 5) chk("R6 wo", wo[0], 0);
            if (j == 0) begin cc_wr = 2'b01; cc_in = 16'h0003; end
            if (j == 1) cc_wr = 2'b00;
        end
        idle_check();

        // R5: same write in zero-only mode waits for zero.
        load_cfg(1'b1, 0, 1, 4, 0, 0);
        enable = 1'b1;
        for (int j = 0; j <= 9; j++) begin
            @(negedge clk);
            if (j == 5) chk("R5 wo", wo[0], 1);
            if (j == 8) chk("R5 wo", wo[0], 0);
            if (j == 9) chk("R5 wo", wo[0], 0);
            if (j == 0) begin cc_wr = 2'b01; cc_in = 16'h0003; end
            if (j == 1) cc_wr = 2'b00;
        end
        idle_check();

        // R10: unbuffered write acts at once.
        load_cfg(1'b1, 0, 1, 4, 0, 0);
        buf_en = 1'b0;
        enable = 1'b1;
        for (int j = 0; j <= 3; j++) begin
            @(negedge clk);
            if (j == 0) chk("R10 wo", wo[0], 1);
            if (j == 1) chk("R10 wo", wo[0], 0);
            if (j == 2) chk("R10 wo", wo[0], 0);
            if (j == 0) begin cc_wr = 2'b01; cc_in = 16'h0003; end
            if (j == 1) cc_wr = 2'b00;
        end
        idle_check();
        buf_en = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule